// File: doc/BRIEF.md
# Two-Pin LSB-Justified Serial Audio Receiver

This block deserialises audio samples for the external-filter input of a digital-to-analog converter. Left-channel bits arrive on one data pin and right-channel bits on another, both sampled on the rising edge of a continuous bit clock. A word clock marks the sample period; its period may hold many more bit clocks than one sample. Each sample is right-aligned in the period, so the final bit before the word clock rises is the least significant bit.

A three-bit format code selects the sample length: 16, 24 or 32 bits. Shorter samples are sign-extended to the output width. The code is taken only at a word boundary. A parallel left/right pair leaves the block with a one-cycle valid strobe. Reserved codes raise an error flag and suppress output. All logic runs on the bit clock.

Top module: `lsbj_audio_rx`

## Requirements
- R1: While reset is asserted, and after it is released, both sample outputs are zero, the valid strobe is low, the error flag is low, and the active format is the 32-bit code 101.
- R2: Both data pins are sampled on every rising bit-clock edge into independent channels: left-pin data appears only on the left output and right-pin data only on the right output.
- R3: Under code 101 the sample is the last 32 bits received before the word boundary, with the first received bit as bit 31. Bits received earlier in the period have no effect.
- R4: Under code 100 the sample is the last 24 bits before the boundary, first received bit as bit 23, and bit 23 is copied into bits 31..24.
- R5: Under code 000 the sample is the last 16 bits before the boundary, first received bit as bit 15, and bit 15 is copied into bits 31..16.
- R6: Codes 001, 010, 011, 110 and 111 are invalid. The error flag is high exactly while an invalid code is active. A boundary that closes a word under an invalid code gives no valid strobe and leaves the outputs unchanged.
- R7: The format code is sampled only on the bit-clock edge that sees the word boundary. The word closed at that edge is decoded with the code that was active during its period. A change of the code in mid-word has no effect before the next boundary.
- R8: A word boundary is a bit-clock edge that samples the word clock high when the previous edge sampled it low. Reset counts the word clock as last seen low. The valid strobe is high for exactly the one cycle after each boundary with a valid active format.
- R9: Between valid strobes both sample outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk_i | input | 1 | Bit clock; all logic runs on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wclk_i | input | 1 | Word clock; its rising edge marks the boundary |
| dat_l_i | input | 1 | Left-channel serial data, MSB first |
| dat_r_i | input | 1 | Right-channel serial data, MSB first |
| fmt_i | input | 3 | Format code (000: 16 bit, 100: 24 bit, 101: 32 bit) |
| smp_l_o | output | 32 | Left sample, sign-extended |
| smp_r_o | output | 32 | Right sample, sign-extended |
| smp_vld_o | output | 1 | One-cycle strobe marking a new sample pair |
| fmt_err_o | output | 1 | High while the active format code is invalid |

## Verification
The assertions assume that the word clock is synchronous to the bit clock and holds each level for at least one bit-clock cycle. This keeps two boundaries from falling on adjacent edges. They also assume the word-clock period is at least as long as the selected sample length. The stimulus drives every input on the falling bit-clock edge. It uses word-clock periods of 32, 48, 64 and 96 bit clocks with a half-period high phase, and always fits the sample inside the period. The format code is changed at boundaries and, deliberately, in mid-word, and random bits fill the part of each period ahead of the sample.

// File: rtl/lsbj_pkg.sv
package lsbj_pkg;

   typedef enum logic [1:0] {
      LEN_NONE = 2'd0,
      LEN_16   = 2'd1,
      LEN_24   = 2'd2,
      LEN_32   = 2'd3
   } len_e;

   localparam logic [2:0] FMT_L16 = 3'b000;
   localparam logic [2:0] FMT_L24 = 3'b100;
   localparam logic [2:0] FMT_L32 = 3'b101;

   function automatic len_e fmt_decode(input logic [2:0] code);
      case (code)
         FMT_L16: fmt_decode = LEN_16;
         FMT_L24: fmt_decode = LEN_24;
         FMT_L32: fmt_decode = LEN_32;
         default: fmt_decode = LEN_NONE;
      endcase
   endfunction

endpackage

// File: rtl/lsbj_word_edge.sv
module lsbj_word_edge (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic wclk_i,
   output logic wclk_q_o,
   output logic rise_o
);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) wclk_q_o <= 1'b0;
      else         wclk_q_o <= wclk_i;
   end

   assign rise_o = wclk_i & ~wclk_q_o;

endmodule

// File: rtl/lsbj_fmt_ctl.sv
module lsbj_fmt_ctl
   import lsbj_pkg::*;
#(
   parameter logic [2:0] FMT_DEF = 3'b101
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic [2:0] fmt_i,
   input  logic       bnd_i,
   output len_e       len_o,
   output logic       err_o
);

   logic [2:0] act_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    act_q <= FMT_DEF;
      else if (bnd_i) act_q <= fmt_i;
   end

   assign len_o = fmt_decode(act_q);
   assign err_o = (len_o == LEN_NONE);

   // R7
   fmt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !bnd_i |=> $stable(act_q));

endmodule

// File: rtl/lsbj_chan.sv
module lsbj_chan
   import lsbj_pkg::*;
#(
   parameter int SHIFT_W  = 32,
   parameter int OUT_W    = 32,
   parameter bit SIGN_EXT = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             din_i,
   input  logic             cap_i,
   input  len_e             len_i,
   output logic [OUT_W-1:0] smp_o
);

   logic [SHIFT_W-1:0] sh_q;
   logic [OUT_W-1:0]   x16, x24, x32, ext;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[SHIFT_W-2:0], din_i};
   end

   generate
      if (SIGN_EXT) begin : g_sext
         assign x16 = OUT_W'($signed(sh_q[15:0]));
         assign x24 = OUT_W'($signed(sh_q[23:0]));
         assign x32 = OUT_W'($signed(sh_q[31:0]));

         // R5
         sext16_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            cap_i && (len_i == LEN_16) |=>
               (smp_o[OUT_W-1:15] == '0) || (smp_o[OUT_W-1:15] == '1));
         // R4
         sext24_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            cap_i && (len_i == LEN_24) |=>
               (smp_o[OUT_W-1:23] == '0) || (smp_o[OUT_W-1:23] == '1));
      end else begin : g_zext
         assign x16 = OUT_W'(sh_q[15:0]);
         assign x24 = OUT_W'(sh_q[23:0]);
         assign x32 = OUT_W'(sh_q[31:0]);
      end
   endgenerate

   always_comb begin
      case (len_i)
         LEN_16:  ext = x16;
         LEN_24:  ext = x24;
         LEN_32:  ext = x32;
         default: ext = '0;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    smp_o <= '0;
      else if (cap_i) smp_o <= ext;
   end

endmodule

// File: rtl/lsbj_audio_rx.sv
module lsbj_audio_rx
   import lsbj_pkg::*;
#(
   parameter int         SHIFT_W  = 32,
   parameter int         OUT_W    = 32,
   parameter bit         SIGN_EXT = 1'b1,
   parameter logic [2:0] FMT_DEF  = FMT_L32
) (
   input  logic             bclk_i,
   input  logic             rst_ni,
   input  logic             wclk_i,
   input  logic             dat_l_i,
   input  logic             dat_r_i,
   input  logic [2:0]       fmt_i,
   output logic [OUT_W-1:0] smp_l_o,
   output logic [OUT_W-1:0] smp_r_o,
   output logic             smp_vld_o,
   output logic             fmt_err_o
);

   localparam int N_CH    = 2;
   localparam int MAX_LEN = 32;

   generate
      if (SHIFT_W < MAX_LEN) begin : g_bad_shift
         $error("SHIFT_W must cover the longest sample");
      end
      if (OUT_W < MAX_LEN) begin : g_bad_out
         $error("OUT_W must cover the longest sample");
      end
      if (FMT_DEF != FMT_L16 && FMT_DEF != FMT_L24 && FMT_DEF != FMT_L32) begin : g_bad_def
         $error("FMT_DEF must be a valid format code");
      end
   endgenerate

   logic wclk_q_w, rise_w, cap_w, err_w;
   len_e len_w;
   logic [N_CH-1:0]            din_w;
   logic [N_CH-1:0][OUT_W-1:0] smp_w;

   lsbj_word_edge u_edge (
      .clk_i    (bclk_i),
      .rst_ni   (rst_ni),
      .wclk_i   (wclk_i),
      .wclk_q_o (wclk_q_w),
      .rise_o   (rise_w)
   );

   lsbj_fmt_ctl #(.FMT_DEF(FMT_DEF)) u_fmt (
      .clk_i  (bclk_i),
      .rst_ni (rst_ni),
      .fmt_i  (fmt_i),
      .bnd_i  (rise_w),
      .len_o  (len_w),
      .err_o  (err_w)
   );

   assign cap_w = rise_w & ~err_w;
   assign din_w = {dat_r_i, dat_l_i};

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      lsbj_chan #(
         .SHIFT_W  (SHIFT_W),
         .OUT_W    (OUT_W),
         .SIGN_EXT (SIGN_EXT)
      ) u_chan (
         .clk_i  (bclk_i),
         .rst_ni (rst_ni),
         .din_i  (din_w[c]),
         .cap_i  (cap_w),
         .len_i  (len_w),
         .smp_o  (smp_w[c])
      );
   end

   assign smp_l_o = smp_w[0];
   assign smp_r_o = smp_w[1];

   always_ff @(posedge bclk_i or negedge rst_ni) begin
      if (!rst_ni) smp_vld_o <= 1'b0;
      else         smp_vld_o <= cap_w;
   end

   assign fmt_err_o = err_w;

   // R8
   vld_single_chk: assert property (@(posedge bclk_i) disable iff (!rst_ni)
      smp_vld_o |=> !smp_vld_o);
   // R8
   vld_rise_chk: assert property (@(posedge bclk_i) disable iff (!rst_ni)
      smp_vld_o |-> $past(wclk_i) && !$past(wclk_q_w));
   // R6
   vld_fmt_chk: assert property (@(posedge bclk_i) disable iff (!rst_ni)
      smp_vld_o |-> !$past(fmt_err_o));
   // R9
   hold_chk: assert property (@(posedge bclk_i) disable iff (!rst_ni)
      !smp_vld_o |-> $stable(smp_l_o) && $stable(smp_r_o));

endmodule

// File: tb/lsbj_audio_rx_bench.sv
module lsbj_audio_rx_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wclk = 1'b0;
   logic        dl = 1'b0, dr = 1'b0;
   logic [2:0]  fmt = 3'b101;
   logic [31:0] smp_l, smp_r;
   logic        vld, err;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #4 clk = ~clk;

   lsbj_audio_rx u_lsbj_audio_rx (
      .bclk_i    (clk),
      .rst_ni    (rst_n),
      .wclk_i    (wclk),
      .dat_l_i   (dl),
      .dat_r_i   (dr),
      .fmt_i     (fmt),
      .smp_l_o   (smp_l),
      .smp_r_o   (smp_r),
      .smp_vld_o (vld),
      .fmt_err_o (err)
   );

   function automatic int len_of(input logic [2:0] c);
      if (c == 3'b000) return 16;
      if (c == 3'b100) return 24;
      if (c == 3'b101) return 32;
      return 0;
   endfunction

   // ---------------- reference model ----------------
   bit          ql[$];
   bit          qr[$];
   logic        m_prev_w;
   logic [2:0]  m_act;
   logic [31:0] e_l, e_r;
   logic        e_v, e_err;
   int          e_len;
   bit          m_mid, e_mid;

   function automatic logic [31:0] pick(input bit q[$], input int n);
      logic [31:0] v = '0;
      for (int i = 0; i < n; i++) v = {v[30:0], q[q.size() - n + i]};
      if (n < 32 && v[n-1]) v = v | ~((32'd1 << n) - 32'd1);
      return v;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         ql = {}; qr = {};
         for (int i = 0; i < 32; i++) begin ql.push_back(1'b0); qr.push_back(1'b0); end
         m_prev_w = 1'b0; m_act = 3'b101;
         e_l = '0; e_r = '0; e_v = 1'b0; e_err = 1'b0; e_len = 32;
         m_mid = 1'b0; e_mid = 1'b0;
      end else begin
         e_v = 1'b0;
         if (wclk && !m_prev_w) begin
            if (len_of(m_act) != 0) begin
               e_len = len_of(m_act);
               e_l = pick(ql, e_len);
               e_r = pick(qr, e_len);
               e_v = 1'b1;
               e_mid = m_mid;
            end
            m_act = fmt;
            m_mid = 1'b0;
         end else if (fmt != m_act) begin
            m_mid = 1'b1;
         end
         ql.push_back(dl); void'(ql.pop_front());
         qr.push_back(dr); void'(qr.pop_front());
         m_prev_w = wclk;
         e_err = (len_of(m_act) == 0);
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // compare on every falling edge once out of reset
   always @(negedge clk) begin
      if (rst_n && !done) begin
         string dtag;
         chk(vld === e_v, "R8 valid strobe", {31'd0, vld}, {31'd0, e_v});
         chk(err === e_err, "R6 error flag", {31'd0, err}, {31'd0, e_err});
         if (e_v) begin
            dtag = (e_len == 32) ? "R3" : (e_len == 24) ? "R4" : "R5";
            if (e_mid) dtag = {dtag, " R7"};
            chk(smp_l === e_l, {dtag, " R2 left sample"}, smp_l, e_l);
            chk(smp_r === e_r, {dtag, " R2 right sample"}, smp_r, e_r);
         end else begin
            chk(smp_l === e_l, "R9 left hold", smp_l, e_l);
            chk(smp_r === e_r, "R9 right hold", smp_r, e_r);
         end
      end
   end

   // one word-clock period; the sample sits at the end of the period
   task automatic word(input int dw, input logic [2:0] f0, input logic [2:0] fmid,
                       input int n, input logic [31:0] l, input logic [31:0] r);
      for (int k = 0; k < dw; k++) begin
         @(negedge clk);
         wclk = (k < dw / 2);
         if (k == 0)      fmt = f0;
         if (k == dw / 2) fmt = fmid;
         if (n > 0 && k >= dw - n) begin
            dl = l[n - 1 - (k - (dw - n))];
            dr = r[n - 1 - (k - (dw - n))];
         end else begin
            dl = 1'($urandom);
            dr = 1'($urandom);
         end
      end
   endtask

   initial begin
      #(8 * 200000);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      // R1: reset state
      chk(smp_l === 32'd0 && smp_r === 32'd0, "R1 reset samples", smp_l, 32'd0);
      chk(vld === 1'b0 && err === 1'b0, "R1 reset flags", {30'd0, vld, err}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(vld === 1'b0 && err === 1'b0, "R1 after release", {30'd0, vld, err}, 32'd0);

      // R3: 32-bit, long and tight periods
      word(64, 3'b101, 3'b101, 32, 32'h8765_4321, 32'h0123_4567);
      word(64, 3'b101, 3'b101, 32, 32'hFFFF_0000, 32'h0000_FFFF);
      word(32, 3'b101, 3'b101, 32, 32'hA5A5_5A5A, 32'h5A5A_A5A5);
      word(96, 3'b101, 3'b101, 32, $urandom, $urandom);
      // R7: code moves to 16-bit in mid-word; this word still closes as 32-bit
      word(64, 3'b101, 3'b000, 32, 32'h8000_1234, 32'h7FFF_8001);
      // R5: 16-bit, negative and positive
      word(48, 3'b000, 3'b000, 16, 32'h0000_8001, 32'h0000_7FFE);
      word(32, 3'b000, 3'b000, 16, 32'h0000_FFFF, 32'h0000_0001);
      // R4: 24-bit
      word(48, 3'b000, 3'b100, 16, 32'h0000_C3C3, 32'h0000_3C3C);
      word(48, 3'b100, 3'b100, 24, 32'h0080_0000, 32'h007F_FFFF);
      word(96, 3'b100, 3'b100, 24, 32'h00AB_CDEF, 32'h0012_3456);
      // R6: every reserved code, then recovery
      word(32, 3'b011, 3'b011, 24, 32'h00DE_ADBE, 32'h00EF_0000);
      word(32, 3'b001, 3'b010, 0, '0, '0);
      word(32, 3'b010, 3'b110, 0, '0, '0);
      word(32, 3'b110, 3'b111, 0, '0, '0);
      word(32, 3'b111, 3'b111, 0, '0, '0);
      word(48, 3'b101, 3'b101, 32, 32'h1357_9BDF, 32'hECA8_6420);
      for (int i = 0; i < 20; i++) begin
         logic [2:0] c;
         int dw;
         c  = (i % 3 == 0) ? 3'b000 : (i % 3 == 1) ? 3'b100 : 3'b101;
         dw = (i % 2 == 0) ? 64 : 32;
         word(dw, c, c, len_of(c), $urandom, $urandom);
      end
      word(32, 3'b101, 3'b101, 0, '0, '0);
      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule